// File: doc/BRIEF.md
# Dual-Side Scratchpad Register Bank

This block holds the small 32-bit message registers that two sides of a bridge use to talk to each other. One side is the virtual side (side code 0), the other the link side (side code 1). Both reach the bank through a single register access port. Each request carries a side code, a peer flag, a write flag, a logical index and write data. The peer flag turns the request towards the registers that the other side owns. A clear command zeroes every visible register of one owner, one register per cycle.

The storage is made of a primary group (8 registers by default) and an extra group (4 by default). The extra group counts as present only if a write of 0x12345678 to it reads back unchanged. In back-to-back mode (`b2b_mode`=1) each side owns a full private copy of both groups. In shared mode (`b2b_mode`=0) a single physical copy is split. The link side owns the upper half of each group and the virtual side owns the lower half. The mapping follows `b2b_mode` combinationally, and the stored contents stay in place when the mode changes.

The controller is a four-state machine:
- PROBE: the first state after reset. It writes the test word to extra register 0 of physical copy 0. It always moves to CHECK.
- CHECK: it compares the read-back value, records `ext_present`, writes zero back to the probed register and moves to IDLE.
- IDLE: it serves requests. A clear command moves it to CLEAR.
- CLEAR: it writes zero to logical indices 0 upwards and returns to IDLE after the last visible index.

Top module: `spad_bank`

## Requirements
- R1: Reset clears every register, `rvalid`, `err`, `rdata` and `ext_present` to 0. `ready` rises two clocks after reset is released (PROBE, then CHECK). Every accepted read made after that returns 0 until something is written.
- R2: `ext_present` becomes 1 in CHECK only when the probe word 0x12345678 reads back unchanged from the extra group. The probed register is left at zero, and `ext_present` does not change afterwards until reset.
- R3: `vis_count` is the number of visible registers per side. In back-to-back mode it is 8 plus 4 when the extra group is present. In shared mode it is 4 plus 2 when the extra group is present.
- R4: A logical index below the visible primary count selects primary register `index`. A higher visible index selects extra register `index - primary count`.
- R5: The owner of a request is `req_side XOR req_peer`. In back-to-back mode the two owners have disjoint full copies. A peer access reads and writes the copy that the other side sees as its own.
- R6: In shared mode, logical index i of the link side's own primary view is physical primary i+4 of copy 0. Its extra index e is physical extra e+2 of copy 0. The virtual side owns physical primary 0..3 and extra 0..1. These positions can be seen by switching to back-to-back mode and reading the virtual side's own view.
- R7: A request whose index is at or above `vis_count` is rejected. `err` is high for exactly the next cycle, nothing is written, and a rejected read returns `rdata`=0.
- R8: A read request gives `rvalid`=1 in the next cycle, with the data in `rdata`. `rdata` is 0 whenever `rvalid` is 0.
- R9: A clear command (`clr_req`, which takes its owner from `req_side XOR req_peer`) holds `ready` low for `vis_count` cycles. In that time it writes zero to every visible register of that owner. Registers of the other owner are not touched.
- R10: A request made while `ready` is low, or in the same cycle as an accepted `clr_req`, is rejected with `err` and has no effect.
- R11: With `ext_en`=0 the extra group is not present. `ext_present` stays 0 and indices at or above the primary count are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b2b_mode | input | 1 | 1: private copy per side; 0: one copy split in halves |
| ext_en | input | 1 | Extra group physically enabled |
| req | input | 1 | Access request, one cycle |
| req_side | input | 1 | Requesting side: 0 virtual, 1 link |
| req_peer | input | 1 | Target the other side's registers |
| req_write | input | 1 | 1 write, 0 read |
| req_idx | input | 4 | Logical register index |
| req_wdata | input | 32 | Write data |
| clr_req | input | 1 | Start clearing the target owner's visible registers |
| ready | output | 1 | Controller idle and accepting requests |
| rvalid | output | 1 | Read response this cycle |
| rdata | output | 32 | Read data, 0 when rejected or not a read |
| err | output | 1 | Previous request was rejected |
| ext_present | output | 1 | Extra group detected |
| vis_count | output | 4 | Registers visible to each side |

## Verification
The bench builds the bank with the default 8 primary and 4 extra registers. With these sizes the 4-bit index reaches 12 to 15, which lie past every visible count. The shared-mode halves (4 primary, 2 extra) are small enough to check one by one. The bench flips `b2b_mode` at run time, so the shared-mode layout becomes visible through the virtual side's back-to-back view. It also runs a second reset with `ext_en` low to cover the failed probe. Clears are exercised in shared mode, including requests that collide with the clear command.

// File: rtl/spad_pkg.sv
package spad_pkg;
    typedef enum logic [1:0] {
        ST_PROBE,
        ST_CHECK,
        ST_IDLE,
        ST_CLEAR
    } spad_state_e;

    localparam logic [31:0] PROBE_WORD = 32'h1234_5678;
endpackage

// File: rtl/spad_map.sv
module spad_map #(
    parameter int PRI_N = 8,
    parameter int EXT_N = 4,
    parameter int IDXW  = 4,
    parameter int SW    = 4,
    parameter int CNTW  = 4
) (
    input  logic            b2b,
    input  logic            ext_on,
    input  logic            tgt,
    input  logic [IDXW-1:0] idx,
    output logic            hit,
    output logic            bank,
    output logic [SW-1:0]   slot,
    output logic [CNTW-1:0] vis
);
    localparam int PRI_HALF = PRI_N / 2;
    localparam int EXT_HALF = EXT_N / 2;
    localparam int NREG     = PRI_N + EXT_N;

    always_comb begin
        int pri_vis;
        int ext_vis;
        int ii;
        int s;
        pri_vis = b2b ? PRI_N : PRI_HALF;
        ext_vis = !ext_on ? 0 : (b2b ? EXT_N : EXT_HALF);
        ii      = int'(idx);
        if (ii < pri_vis)
            s = ii + ((!b2b && tgt) ? PRI_HALF : 0);
        else
            s = PRI_N + (ii - pri_vis) + ((!b2b && tgt) ? EXT_HALF : 0);
        hit  = ii < (pri_vis + ext_vis);
        slot = hit ? SW'(s) : '0;
        bank = b2b & tgt;
        vis  = CNTW'(pri_vis + ext_vis);
    end

    always_comb begin
        if (hit) begin
            assert_slot_range_R4: assert (int'(slot) < NREG);
        end
        if (hit && !b2b && tgt) begin
            assert_link_upper_R6: assert ((int'(slot) < PRI_N) ? (int'(slot) >= PRI_HALF)
                                                               : (int'(slot) >= PRI_N + EXT_HALF));
        end
    end
endmodule

// File: rtl/spad_store.sv
module spad_store #(
    parameter int DW    = 32,
    parameter int PRI_N = 8,
    parameter int NREG  = 12,
    parameter int SW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_en,
    input  logic          we,
    input  logic          bank,
    input  logic [SW-1:0] slot,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int NCOPY = 2;

    logic [NCOPY*NREG*DW-1:0] flat;

    for (genvar b = 0; b < NCOPY; b++) begin : g_copy
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            localparam bit IS_EXT = (k >= PRI_N);
            logic [DW-1:0] q;
            logic          sel;
            assign sel = we && (bank == (b != 0)) && (int'(slot) == k) && (!IS_EXT || ext_en);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (sel)
                    q <= wdata;
            end
            assign flat[(b*NREG+k)*DW +: DW] = q;
        end
    end

    always_comb begin
        if ((!ext_en && int'(slot) >= PRI_N) || int'(slot) >= NREG)
            rdata = '0;
        else
            rdata = flat[(int'(bank)*NREG + int'(slot))*DW +: DW];
    end
endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
    import spad_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PRI_N = 8,
    parameter int IDXW  = 4,
    parameter int SW    = 4,
    parameter int CNTW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            req_side,
    input  logic            req_peer,
    input  logic            req_write,
    input  logic [IDXW-1:0] req_idx,
    input  logic [DW-1:0]   req_wdata,
    input  logic            clr_req,
    output logic [IDXW-1:0] map_idx,
    output logic            map_tgt,
    input  logic            map_hit,
    input  logic            map_bank,
    input  logic [SW-1:0]   map_slot,
    input  logic [CNTW-1:0] vis_count,
    output logic            st_we,
    output logic            st_bank,
    output logic [SW-1:0]   st_slot,
    output logic [DW-1:0]   st_wdata,
    input  logic [DW-1:0]   st_rdata,
    output logic            ready,
    output logic            rvalid,
    output logic [DW-1:0]   rdata,
    output logic            err,
    output logic            ext_present
);
    spad_state_e     state;
    spad_state_e     nxt;
    logic [CNTW-1:0] clr_cnt;
    logic            clr_tgt;
    logic            accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_PROBE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt      = state;
        map_idx  = req_idx;
        map_tgt  = req_side ^ req_peer;
        st_we    = 1'b0;
        st_bank  = map_bank;
        st_slot  = map_slot;
        st_wdata = req_wdata;
        accept   = 1'b0;
        unique case (state)
            ST_PROBE: begin
                st_we    = 1'b1;
                st_bank  = 1'b0;
                st_slot  = SW'(PRI_N);
                st_wdata = DW'(PROBE_WORD);
                nxt      = ST_CHECK;
            end
            ST_CHECK: begin
                st_we    = 1'b1;
                st_bank  = 1'b0;
                st_slot  = SW'(PRI_N);
                st_wdata = '0;
                nxt      = ST_IDLE;
            end
            ST_IDLE: begin
                if (clr_req) begin
                    nxt = ST_CLEAR;
                end else if (req && map_hit) begin
                    accept = 1'b1;
                    st_we  = req_write;
                end
            end
            ST_CLEAR: begin
                map_idx  = IDXW'(clr_cnt);
                map_tgt  = clr_tgt;
                st_we    = 1'b1;
                st_wdata = '0;
                if (clr_cnt == vis_count - CNTW'(1))
                    nxt = ST_IDLE;
            end
        endcase
    end

    assign ready = (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_present <= 1'b0;
            clr_cnt     <= '0;
            clr_tgt     <= 1'b0;
            rvalid      <= 1'b0;
            err         <= 1'b0;
            rdata       <= '0;
        end else begin
            if (state == ST_CHECK)
                ext_present <= (st_rdata == DW'(PROBE_WORD));
            if (state == ST_IDLE && clr_req) begin
                clr_cnt <= '0;
                clr_tgt <= req_side ^ req_peer;
            end else if (state == ST_CLEAR) begin
                clr_cnt <= clr_cnt + CNTW'(1);
            end
            rvalid <= req && !req_write;
            err    <= req && !accept;
            rdata  <= (accept && !req_write) ? st_rdata : '0;
        end
    end

    assert_err_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req));
    assert_reject_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && err) |-> (rdata == '0));
    assert_rvalid_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !req_write));
    assert_ext_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(ext_present));
endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
    parameter int DW    = 32,
    parameter int PRI_N = 8,
    parameter int EXT_N = 4,
    parameter int IDXW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            b2b_mode,
    input  logic            ext_en,
    input  logic            req,
    input  logic            req_side,
    input  logic            req_peer,
    input  logic            req_write,
    input  logic [IDXW-1:0] req_idx,
    input  logic [DW-1:0]   req_wdata,
    input  logic            clr_req,
    output logic            ready,
    output logic            rvalid,
    output logic [DW-1:0]   rdata,
    output logic            err,
    output logic            ext_present,
    output logic [3:0]      vis_count
);
    localparam int NREG = PRI_N + EXT_N;
    localparam int SW   = $clog2(NREG);
    localparam int CNTW = 4;

    logic [IDXW-1:0] map_idx;
    logic            map_tgt;
    logic            map_hit;
    logic            map_bank;
    logic [SW-1:0]   map_slot;
    logic [CNTW-1:0] vis;
    logic            st_we;
    logic            st_bank;
    logic [SW-1:0]   st_slot;
    logic [DW-1:0]   st_wdata;
    logic [DW-1:0]   st_rdata;

    spad_map #(.PRI_N(PRI_N), .EXT_N(EXT_N), .IDXW(IDXW), .SW(SW), .CNTW(CNTW)) u_map (
        .b2b    (b2b_mode),
        .ext_on (ext_present),
        .tgt    (map_tgt),
        .idx    (map_idx),
        .hit    (map_hit),
        .bank   (map_bank),
        .slot   (map_slot),
        .vis    (vis)
    );

    spad_store #(.DW(DW), .PRI_N(PRI_N), .NREG(NREG), .SW(SW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_en (ext_en),
        .we     (st_we),
        .bank   (st_bank),
        .slot   (st_slot),
        .wdata  (st_wdata),
        .rdata  (st_rdata)
    );

    spad_ctrl #(.DW(DW), .PRI_N(PRI_N), .IDXW(IDXW), .SW(SW), .CNTW(CNTW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_side    (req_side),
        .req_peer    (req_peer),
        .req_write   (req_write),
        .req_idx     (req_idx),
        .req_wdata   (req_wdata),
        .clr_req     (clr_req),
        .map_idx     (map_idx),
        .map_tgt     (map_tgt),
        .map_hit     (map_hit),
        .map_bank    (map_bank),
        .map_slot    (map_slot),
        .vis_count   (vis),
        .st_we       (st_we),
        .st_bank     (st_bank),
        .st_slot     (st_slot),
        .st_wdata    (st_wdata),
        .st_rdata    (st_rdata),
        .ready       (ready),
        .rvalid      (rvalid),
        .rdata       (rdata),
        .err         (err),
        .ext_present (ext_present)
    );

    assign vis_count = vis;

    assert_ext_needs_strap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_present |-> ext_en);
endmodule

// File: tb/test_spad_bank.sv
module test_spad_bank;
    localparam int PRI = 8;
    localparam int EXT = 4;
    localparam int NR  = PRI + EXT;
    localparam logic [31:0] PAT = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b2b_mode = 1'b1;
    logic        ext_en = 1'b1;
    logic        req = 1'b0;
    logic        req_side = 1'b0;
    logic        req_peer = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic        clr_req = 1'b0;
    logic        ready;
    logic        rvalid;
    logic [31:0] rdata;
    logic        err;
    logic        ext_present;
    logic [3:0]  vis_count;

    always #4 clk = ~clk;

    spad_bank i_spad_bank (
        .clk(clk), .rst_n(rst_n), .b2b_mode(b2b_mode), .ext_en(ext_en),
        .req(req), .req_side(req_side), .req_peer(req_peer), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .clr_req(clr_req),
        .ready(ready), .rvalid(rvalid), .rdata(rdata), .err(err),
        .ext_present(ext_present), .vis_count(vis_count)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    string       tag = "R1";
    int          m_phase = 0;
    bit          m_ext = 1'b0;
    logic [31:0] mm [2][NR];
    bit          m_rv = 1'b0;
    bit          m_er = 1'b0;
    logic [31:0] m_rd = '0;
    bit          ct = 1'b0;
    int          cc = 0;
    int          bk;
    int          sl;
    bit          h;

    function automatic int vis_of(bit b, bit e);
        int p = b ? PRI : PRI / 2;
        int x = e ? (b ? EXT : EXT / 2) : 0;
        return p + x;
    endfunction

    function automatic bit locate(bit b, bit owner, int idx, bit e, output int obk, output int osl);
        int p = b ? PRI : PRI / 2;
        obk = b ? int'(owner) : 0;
        if (idx >= p)
            osl = PRI + (idx - p) + ((!b && owner) ? EXT / 2 : 0);
        else
            osl = idx + ((!b && owner) ? PRI / 2 : 0);
        return idx < vis_of(b, e);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ext = 1'b0; m_rv = 1'b0; m_er = 1'b0; m_rd = '0;
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < NR; k++)
                    mm[b][k] = '0;
        end else begin
            m_rv = req && !req_write;
            m_er = 1'b0;
            m_rd = '0;
            case (m_phase)
                0: begin
                    if (ext_en) mm[0][PRI] = PAT;
                    m_er = req;
                    m_phase = 1;
                end
                1: begin
                    m_ext = ext_en;
                    mm[0][PRI] = '0;
                    m_er = req;
                    m_phase = 2;
                end
                2: begin
                    if (clr_req) begin
                        m_er = req;
                        ct = req_side ^ req_peer;
                        cc = 0;
                        m_phase = 3;
                    end else if (req) begin
                        h = locate(b2b_mode, req_side ^ req_peer, int'(req_idx), m_ext, bk, sl);
                        if (!h) m_er = 1'b1;
                        else if (req_write) mm[bk][sl] = req_wdata;
                        else m_rd = mm[bk][sl];
                    end
                end
                default: begin
                    m_er = req;
                    h = locate(b2b_mode, ct, cc, m_ext, bk, sl);
                    mm[bk][sl] = '0;
                    cc++;
                    if (cc == vis_of(b2b_mode, m_ext)) m_phase = 2;
                end
            endcase
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("ready", 32'(ready), 32'(m_phase == 2));
            chk("rvalid", 32'(rvalid), 32'(m_rv));
            chk("err", 32'(err), 32'(m_er));
            chk("rdata", rdata, m_rd);
            chk("ext_present", 32'(ext_present), 32'(m_ext));
            chk("vis_count", 32'(vis_count), 32'(vis_of(b2b_mode, m_ext)));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog act=%0d exp=below 20000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic acc(bit side, bit peer, bit wr, int idx, logic [31:0] d);
        req = 1'b1; req_side = side; req_peer = peer; req_write = wr;
        req_idx = 4'(idx); req_wdata = d;
        @(posedge clk); #1;
        req = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic clr(bit side, bit peer, bit with_req, int idx);
        clr_req = 1'b1; req_side = side; req_peer = peer;
        req = with_req; req_write = with_req; req_idx = 4'(idx); req_wdata = 32'hDEAD_0000;
        @(posedge clk); #1;
        clr_req = 1'b0; req = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        tag = "R1";
        acc(0, 0, 0, 3, '0);
        idle(3);
        for (int i = 0; i < NR; i++) acc(0, 0, 0, i, '0);
        tag = "R2";
        idle(2);
        tag = "R4";
        for (int i = 0; i < NR; i++) acc(0, 0, 1, i, 32'hA000_0000 + 32'(i));
        for (int i = 0; i < NR; i++) acc(0, 0, 0, i, '0);
        acc(0, 0, 1, 9, 32'h0000_0909);
        acc(0, 0, 0, 9, '0);
        tag = "R5";
        for (int i = 0; i < NR; i++) acc(1, 0, 0, i, '0);
        for (int i = 0; i < NR; i++) acc(1, 1, 0, i, '0);
        acc(0, 1, 1, 2, 32'hB5B5_0002);
        acc(1, 0, 0, 2, '0);
        acc(0, 0, 0, 2, '0);
        tag = "R7";
        acc(0, 0, 1, 12, 32'hEEEE_0012);
        acc(0, 0, 1, 15, 32'hEEEE_0015);
        acc(0, 0, 0, 12, '0);
        acc(1, 1, 0, 15, '0);
        for (int i = 0; i < NR; i++) acc(0, 0, 0, i, '0);
        tag = "R8";
        acc(0, 0, 0, 0, '0);
        idle(1);
        acc(0, 0, 0, 1, '0);
        tag = "R3";
        b2b_mode = 1'b0;
        idle(2);
        tag = "R6";
        acc(1, 0, 1, 0, 32'hC100_0000);
        acc(1, 0, 1, 4, 32'hC100_0004);
        acc(0, 0, 1, 0, 32'hC000_0000);
        acc(0, 0, 1, 5, 32'hC000_0005);
        acc(0, 0, 1, 6, 32'hC000_0006);
        for (int i = 0; i < 6; i++) acc(0, 1, 0, i, '0);
        for (int i = 0; i < 6; i++) acc(1, 1, 0, i, '0);
        b2b_mode = 1'b1;
        idle(1);
        for (int i = 0; i < NR; i++) acc(0, 0, 0, i, '0);
        b2b_mode = 1'b0;
        idle(1);
        tag = "R9";
        clr(1, 0, 0, 0);
        idle(7);
        for (int i = 0; i < 6; i++) acc(1, 0, 0, i, '0);
        for (int i = 0; i < 6; i++) acc(0, 0, 0, i, '0);
        tag = "R10";
        clr(1, 1, 1, 1);
        acc(0, 0, 1, 2, 32'hDEAD_0002);
        idle(6);
        for (int i = 0; i < 6; i++) acc(0, 0, 0, i, '0);
        tag = "R11";
        rst_n = 1'b0;
        ext_en = 1'b0;
        b2b_mode = 1'b1;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        acc(0, 0, 1, 8, 32'h0808_0808);
        acc(0, 0, 1, 7, 32'h0707_0707);
        acc(0, 0, 0, 7, '0);
        acc(0, 0, 0, 8, '0);
        b2b_mode = 1'b0;
        idle(1);
        acc(1, 0, 0, 4, '0);
        acc(1, 0, 1, 3, 32'h0303_0303);
        acc(1, 0, 0, 3, '0);
        idle(2);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule